// File: doc/BRIEF.md
# Serial Receiver with Hardware Address Filtering

This block receives asynchronous serial frames on one line and turns them into a parallel byte with a receive flag. It works from a one-clock-wide oversampling strobe that runs at sixteen times the bit rate. A two-bit mode input selects either 8-bit frames or 9-bit frames. A 9-bit frame carries an extra data bit before the stop bit. Each completed frame updates a received-data register, a ninth-bit register, a receive-pending flag and a framing-error flag.

For networks with several receivers on one line, a multiprocessor enable turns on hardware address filtering, so the host logic is only interrupted for frames meant for this node. A node address and an address mask define two patterns.
- The unicast pattern compares the node address in the positions where the mask is 1; the other positions are ignored.
- The broadcast pattern is the node address OR the mask, and its zero bits are ignored.

In 9-bit modes, only frames whose ninth bit is 1 count as address frames. In 8-bit mode, the stop bit stands in for the ninth bit. A pending flag that has not been cleared blocks the next frame, which is then dropped. A clear input (`flag_clr`) resets both flags.

Top module: `uart_addr_rx`

## Requirements
- R1: With mode_sel=2'b01 (8-bit mode) and mp_en=0, a frame of a low start bit, 8 data bits sent LSB first and a stop bit loads the byte into rx_data, copies the stop bit into rx_bit9, and sets ri. This holds whatever the stop bit is.
- R2: With mode_sel=2'b10 or 2'b11 (9-bit modes) and mp_en=0, the frame carries a ninth bit after the 8 data bits. That bit goes to rx_bit9, and ri is set.
- R3: A falling edge starts a frame only if the line is still low 8 oversample strobes later, at the middle of the start bit. Otherwise the receiver goes back to idle, and ri and rx_data are left unchanged.
- R4: fe is set when a completed frame has a stop bit sampled low. fe and ri stay set until flag_clr is high for one clock, which clears both.
- R5: With mp_en=1, a frame is accepted when the received byte equals node_addr in every position where addr_mask is 1.
- R6: With mp_en=1, a frame is also accepted when the received byte equals (node_addr | addr_mask) in every position where that OR is 1. Any other address leaves ri clear.
- R7: With mp_en=1 in 9-bit modes, a frame whose ninth bit is 0 never sets ri, even if its byte matches.
- R8: With mp_en=1 in 8-bit mode, a frame sets ri only if its address matches and its stop bit is 1.
- R9: While ri is set and not being cleared, a new frame is dropped: rx_data, rx_bit9 and ri keep their values.
- R10: With rx_en=0, or with mode_sel=2'b00, the receiver ignores the line: ri stays 0 and rx_data does not change.
- R11: After reset, rx_data, rx_bit9, ri and fe are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling strobe, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| mode_sel | input | 2 | 00 off, 01 8-bit, 10/11 9-bit |
| mp_en | input | 1 | Multiprocessor address filtering enable |
| rx_en | input | 1 | Reception enable |
| node_addr | input | 8 | Node address |
| addr_mask | input | 8 | Address mask, 1 = compared |
| flag_clr | input | 1 | Clears ri and fe |
| rx_data | output | 8 | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit, or stop bit in 8-bit mode |
| ri | output | 1 | Frame received, pending |
| fe | output | 1 | Framing error |

## Verification
Random frames cover all three frame modes with filtering on and off. Their bytes are drawn to hit the unicast pattern, the broadcast pattern, or neither, and about one frame in eight has a bad stop bit. This separates unicast matches, broadcast matches and rejections, and it separates a low ninth bit from a bad stop bit.

Directed frames cover the cases random draws would rarely reach:
- a start glitch shorter than half a bit;
- a frame that arrives while ri is still pending;
- reception while disabled or in mode 00;
- a mask example where the two patterns accept different bytes.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP, ST_HOLD} rx_state_t;

  function automatic logic addr_hit(input logic [7:0] d, input logic [7:0] nd,
                                    input logic [7:0] msk);
    logic [7:0] bc;
    bc = nd | msk;
    return (((d ^ nd) & msk) == '0) || (((d ^ bc) & bc) == '0);
  endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], d_in};
  end

  assign d_out = sr[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import uart_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              enable,
  input  logic              nine_bit,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              bit9,
  output logic              stop,
  output logic              busy
);
  localparam int CW   = $clog2(OS_RATE);
  localparam int IW   = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] HALF = CW'(OS_RATE / 2 - 1);
  localparam logic [CW-1:0] FULL = CW'(OS_RATE - 1);

  rx_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic b9_q, b9_d, stp_q, stp_d, done_d, done_q;
  logic [IW-1:0] last_idx;

  assign last_idx = nine_bit ? IW'(DATA_W) : IW'(DATA_W - 1);

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; idx_d = idx_q; sh_d = sh_q;
    b9_d = b9_q; stp_d = stp_q; done_d = 1'b0;
    if (!enable) begin
      st_d = ST_IDLE;
      cnt_d = '0;
    end else if (tick) begin
      case (st_q)
        ST_IDLE: if (!line) begin st_d = ST_START; cnt_d = '0; end
        ST_START: begin
          if (cnt_q == HALF) begin
            cnt_d = '0; idx_d = '0;
            st_d = line ? ST_IDLE : ST_DATA;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_DATA: begin
          if (cnt_q == FULL) begin
            cnt_d = '0;
            if (idx_q < IW'(DATA_W)) sh_d = {line, sh_q[DATA_W-1:1]};
            else                     b9_d = line;
            if (idx_q == last_idx) st_d = ST_STOP;
            idx_d = idx_q + 1'b1;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_STOP: begin
          if (cnt_q == FULL) begin
            cnt_d = '0; stp_d = line; done_d = 1'b1;
            st_d = line ? ST_IDLE : ST_HOLD;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_HOLD: if (line) st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; idx_q <= '0; sh_q <= '0;
      b9_q <= 1'b0; stp_q <= 1'b1; done_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; idx_q <= idx_d; sh_q <= sh_d;
      b9_q <= b9_d; stp_q <= stp_d; done_q <= done_d;
    end
  end

  assign done = done_q;
  assign data = sh_q;
  assign bit9 = b9_q;
  assign stop = stp_q;
  assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/rx_accept.sv
module rx_accept
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] f_data,
  input  logic              f_bit9,
  input  logic              f_stop,
  input  logic              nine_bit,
  input  logic              mp_en,
  input  logic [DATA_W-1:0] node_addr,
  input  logic [DATA_W-1:0] addr_mask,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              ri,
  output logic              fe
);
  logic [DATA_W-1:0] data_d;
  logic bit9_d, ri_d, fe_d, tag_bit, pass, take, pending;

  assign tag_bit = nine_bit ? f_bit9 : f_stop;
  assign pass    = !mp_en || (tag_bit && addr_hit(f_data, node_addr, addr_mask));
  assign pending = ri && !flag_clr;
  assign take    = done && pass && !pending;

  always_comb begin
    data_d = rx_data; bit9_d = rx_bit9;
    ri_d = flag_clr ? 1'b0 : ri;
    fe_d = flag_clr ? 1'b0 : fe;
    if (take) begin
      data_d = f_data; bit9_d = tag_bit; ri_d = 1'b1;
    end
    if (done && !f_stop) fe_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0; rx_bit9 <= 1'b0; ri <= 1'b0; fe <= 1'b0;
    end else begin
      rx_data <= data_d; rx_bit9 <= bit9_d; ri <= ri_d; fe <= fe_d;
    end
  end
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx #(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic [1:0]        mode_sel,
  input  logic              mp_en,
  input  logic              rx_en,
  input  logic [DATA_W-1:0] node_addr,
  input  logic [DATA_W-1:0] addr_mask,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              ri,
  output logic              fe
);
  logic line_s, frm_done, frm_bit9, frm_stop, frm_busy, nine_bit, rx_on;
  logic [DATA_W-1:0] frm_data;

  assign nine_bit = mode_sel[1];
  assign rx_on    = rx_en && (mode_sel != 2'b00);

  rx_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(rxd), .d_out(line_s));

  rx_framer #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_frm (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line_s), .enable(rx_on),
    .nine_bit(nine_bit), .done(frm_done), .data(frm_data), .bit9(frm_bit9),
    .stop(frm_stop), .busy(frm_busy));

  rx_accept #(.DATA_W(DATA_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .done(frm_done), .f_data(frm_data),
    .f_bit9(frm_bit9), .f_stop(frm_stop), .nine_bit(nine_bit), .mp_en(mp_en),
    .node_addr(node_addr), .addr_mask(addr_mask), .flag_clr(flag_clr),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .ri(ri), .fe(fe));
endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic [1:0]        mode_sel,
  input logic              mp_en,
  input logic              flag_clr,
  input logic              frm_done,
  input logic              frm_stop,
  input logic              frm_bit9,
  input logic              frm_busy,
  input logic [DATA_W-1:0] rx_data,
  input logic              ri,
  input logic              fe
);
  AST_RI_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ri) |-> $past(frm_done)); // R1
  AST_FE_BAD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe) |-> $past(frm_done && !frm_stop)); // R4
  AST_MP_NINTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ri) && $past(mp_en && mode_sel[1])) |-> $past(frm_bit9)); // R7
  AST_MP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ri) && $past(mp_en && mode_sel == 2'b01)) |-> $past(frm_stop)); // R8
  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (ri && $past(ri) && !$past(flag_clr)) |-> $stable(rx_data)); // R9
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en || mode_sel == 2'b00) |=> !frm_busy); // R10
endmodule

bind uart_addr_rx uart_addr_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .mode_sel(mode_sel), .mp_en(mp_en),
  .flag_clr(flag_clr), .frm_done(frm_done), .frm_stop(frm_stop),
  .frm_bit9(frm_bit9), .frm_busy(frm_busy), .rx_data(rx_data), .ri(ri), .fe(fe));

// File: tb/sim_uart_addr_rx.sv
module sim_uart_addr_rx;
  localparam int BITCLK = 32;
  logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0, rxd = 1'b1;
  logic [1:0] mode_sel = 2'b01;
  logic mp_en = 1'b0, rx_en = 1'b1, flag_clr = 1'b0;
  logic [7:0] node_addr = '0, addr_mask = '0;
  logic [7:0] rx_data;
  logic rx_bit9, ri, fe;
  int n_run = 0, n_fail = 0;
  logic [7:0] e_data = '0;
  logic e_b9 = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) os_tick <= ~os_tick;

  uart_addr_rx u0 (.clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .mode_sel(mode_sel), .mp_en(mp_en), .rx_en(rx_en), .node_addr(node_addr),
    .addr_mask(addr_mask), .flag_clr(flag_clr), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .ri(ri), .fe(fe));

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic model_hit(input logic [7:0] d, input logic [7:0] nd,
                                     input logic [7:0] m);
    logic u, b;
    u = 1'b1; b = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (m[i] && d[i] != nd[i]) u = 1'b0;
      if ((nd[i] | m[i]) && !d[i]) b = 1'b0;
    end
    return u || b;
  endfunction

  function automatic logic model_take(input logic [1:0] md, input logic sm2,
      input logic [7:0] d, input logic b9, input logic stp, input logic pend);
    logic tag;
    if (md == 2'b00 || pend) return 1'b0;
    tag = md[1] ? b9 : stp;
    if (!sm2) return 1'b1;
    return tag && model_hit(d, node_addr, addr_mask);
  endfunction

  task automatic send(input logic [7:0] d, input logic b9, input logic stp);
    @(negedge clk);
    rxd = 1'b0; repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (BITCLK) @(negedge clk); end
    if (mode_sel[1]) begin rxd = b9; repeat (BITCLK) @(negedge clk); end
    rxd = stp; repeat (BITCLK) @(negedge clk);
    rxd = 1'b1; repeat (BITCLK) @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic frame_check(input logic [7:0] d, input logic b9, input logic stp,
                             input string tag);
    logic tk;
    tk = model_take(mode_sel, mp_en, d, b9, stp, ri);
    if (tk) begin e_data = d; e_b9 = mode_sel[1] ? b9 : stp; end
    send(d, b9, stp);
    chk(ri == tk, {tag, " ri"}, ri, tk);
    chk(rx_data == e_data, {tag, " data"}, rx_data, e_data);
    chk(rx_bit9 == e_b9, {tag, " bit9"}, rx_bit9, e_b9);
    chk(fe == !stp, "R4 fe", fe, !stp);
    clear_flags();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk(ri == 0 && fe == 0 && rx_data == 0 && rx_bit9 == 0, "R11 reset", {ri, fe, rx_bit9}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    mode_sel = 2'b01; frame_check(8'hA5, 1'b0, 1'b1, "R1");
    frame_check(8'h3C, 1'b0, 1'b0, "R1 badstop");
    mode_sel = 2'b11; frame_check(8'h5A, 1'b1, 1'b1, "R2");
    mode_sel = 2'b10; frame_check(8'hC3, 1'b0, 1'b1, "R2 b9=0");

    // R3: short start glitch
    @(negedge clk); rxd = 1'b0; repeat (6) @(negedge clk); rxd = 1'b1;
    repeat (4 * BITCLK) @(negedge clk);
    chk(ri == 0 && rx_data == e_data, "R3 glitch", ri, 0);
    mode_sel = 2'b01; frame_check(8'h81, 1'b0, 1'b1, "R3 after glitch");

    // R5/R6 directed mask example
    mp_en = 1'b1; mode_sel = 2'b11; node_addr = 8'h56; addr_mask = 8'hFC;
    frame_check(8'h57, 1'b1, 1'b1, "R5 unicast");
    frame_check(8'hFE, 1'b1, 1'b1, "R6 broadcast");
    frame_check(8'h16, 1'b1, 1'b1, "R6 reject");
    frame_check(8'h56, 1'b0, 1'b1, "R7 data frame");
    mode_sel = 2'b01;
    frame_check(8'h56, 1'b0, 1'b0, "R8 badstop");
    frame_check(8'h56, 1'b0, 1'b1, "R8 goodstop");

    // R9: pending flag drops next frame
    mp_en = 1'b0;
    send(8'h11, 1'b0, 1'b1);
    e_data = 8'h11; e_b9 = 1'b1;
    mode_sel = 2'b11;
    send(8'h22, 1'b0, 1'b1);
    chk(ri == 1 && rx_data == 8'h11 && rx_bit9 == 1'b1, "R9 pending", rx_data, 8'h11);
    clear_flags();

    // R10: disabled or mode 00
    rx_en = 1'b0; send(8'h99, 1'b1, 1'b1);
    chk(ri == 0 && rx_data == e_data, "R10 rx_en=0", rx_data, e_data);
    rx_en = 1'b1; mode_sel = 2'b00; send(8'h77, 1'b1, 1'b1);
    chk(ri == 0 && rx_data == e_data, "R10 mode00", rx_data, e_data);

    for (int k = 0; k < 40; k++) begin
      logic [7:0] d;
      logic b9, stp;
      mode_sel = 2'($urandom_range(1, 3));
      mp_en = $urandom_range(0, 1);
      node_addr = 8'($urandom); addr_mask = 8'($urandom);
      case ($urandom_range(0, 2))
        0: d = node_addr ^ (8'($urandom) & ~addr_mask);
        1: d = (node_addr | addr_mask) | 8'($urandom);
        default: d = 8'($urandom);
      endcase
      b9 = $urandom_range(0, 1);
      stp = ($urandom_range(0, 7) != 0);
      frame_check(d, b9, stp, mp_en ? "R5 R6 R7 R8 random" : "R1 R2 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule